// File: doc/BRIEF.md
# Prescaled PWM Generator Channel

One pulse-width modulated output, clocked from a fixed reference clock. A power-of-two prescaler (divide by 1 up to 4096) produces a count enable. That enable steps a 16-bit up counter. The counter runs from zero up to a programmed period value, then starts again. The output is active while the count is below a programmed width. A polarity bit sets whether the active level is high or low.

Two modes are available. Cycle mode repeats the waveform for as long as the channel is enabled. Pulse mode waits for a software start bit, emits exactly one period's worth of active-then-inactive output and then stops. The start bit clears itself when that period ends.

Writes to the period and width registers go through shadow copies. While the channel is running, a new value only takes effect at the next period boundary, so no period is ever cut short or stretched. All configuration arrives through a single-cycle register write port.

Top module: `pwm_channel`

## Requirements
- R1: Register writes use the write port: `wr_en` high for one clock, with `wr_addr` selecting the register. Address 0 is control, address 1 is period P and address 2 is width W. The control bits are: [0] enable, [1] pulse mode, [2] invert, [3] start and [7:4] prescale select.
- R2: The prescale select value s divides the count rate by D = 2^s. Values of s above 12 behave as 12, so the largest divisor is 4096.
- R3: Once enabled, the counter holds each value for D clocks and counts 0, 1, …, P. It then returns to 0, so one period lasts (P+1)·D clocks. The first period begins in the clock right after the enabling write.
- R4: In each period the output is active for the first min(W, P+1) counts and inactive for the rest. W = 0 gives an output that is never active. W > P gives an output that is always active.
- R5: With invert = 0 the active level is 1. With invert = 1 the active level is 0.
- R6: While the channel runs, a write to period or width does not affect the current period. It takes effect from the next period boundary.
- R7: While enable is 0, the output rests at the inactive level and the counter is held at zero. After reset, the output is 0. Enabling again restarts a full period from count 0.
- R8: In pulse mode, a control write with enable, pulse mode and start all set emits one period. After that period the output stays inactive until the next start.
- R9: The `armed` output is 1 from the start write until the pulse period ends, then it returns to 0 by itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 1 | PWM waveform |
| armed | output | 1 | Pulse-mode start bit, cleared when the pulse ends |

## Verification
The bench uses the default build: a 16-bit counter and a prescaler log limit of 12. The stimulus table keeps periods short and divisors small, so each vector checks every clock of two full periods against a closed-form model. One directed run uses an out-of-range select value. It reaches the full 4096 divide, which confirms both the clamp and the widest prescaler terminal count. Further directed runs change the width in the middle of a period, and disable and then re-enable the channel while it is running.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  localparam int SEL_W = 4;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_PER  = 2'd1;
  localparam logic [1:0] ADDR_WID  = 2'd2;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             start;
    logic             inv;
    logic             pulse;
    logic             en;
  } ctrl_t;

  // Limit a prescale select value to the largest supported log2 divisor.
  function automatic logic [SEL_W-1:0] clamp_sel(input logic [SEL_W-1:0] sel,
                                                 input int unsigned max_log);
    if (int'(sel) > int'(max_log)) return SEL_W'(max_log);
    return sel;
  endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [CNT_W-1:0]     wr_data,
  input  logic                 pulse_done,
  output logic                 en,
  output logic                 pulse,
  output logic                 inv,
  output logic [SEL_W-1:0]     sel,
  output logic [CNT_W-1:0]     per_reg,
  output logic [CNT_W-1:0]     wid_reg,
  output logic                 armed
);

  ctrl_t wr_ctrl;
  logic  ctrl_wr;

  assign wr_ctrl = ctrl_t'(wr_data[$bits(ctrl_t)-1:0]);
  assign ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      pulse   <= 1'b0;
      inv     <= 1'b0;
      sel     <= '0;
      per_reg <= '0;
      wid_reg <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_CTRL: begin
          en    <= wr_ctrl.en;
          pulse <= wr_ctrl.pulse;
          inv   <= wr_ctrl.inv;
          sel   <= wr_ctrl.sel;
        end
        ADDR_PER: per_reg <= wr_data;
        ADDR_WID: wid_reg <= wr_data;
        default: ;
      endcase
    end
  end

  // Start bit: a control write sets or drops it; a finished pulse clears it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          armed <= 1'b0;
    else if (ctrl_wr)    armed <= wr_ctrl.start & wr_ctrl.en & wr_ctrl.pulse;
    else if (!en)        armed <= 1'b0;
    else if (pulse_done) armed <= 1'b0;
  end

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
#(
  parameter int PRE_LOG = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  localparam int PW = PRE_LOG + 1;

  logic [PRE_LOG-1:0] pcnt;
  logic [PW-1:0]      term;

  assign term = (PW'(1) << clamp_sel(sel, PRE_LOG)) - PW'(1);
  assign tick = run && ({1'b0, pcnt} == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pcnt <= '0;
    else if (!run) pcnt <= '0;
    else if (tick) pcnt <= '0;
    else           pcnt <= pcnt + 1'b1;
  end

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] per_reg,
  input  logic [CNT_W-1:0] wid_reg,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] per_sh,
  output logic [CNT_W-1:0] wid_sh,
  output logic             period_end,
  output logic             active
);

  assign period_end = tick && (cnt == per_sh);
  assign active     = run && (cnt < wid_sh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      per_sh <= '0;
      wid_sh <= '0;
    end else if (!run || period_end) begin
      cnt    <= '0;
      per_sh <= per_reg;
      wid_sh <= wid_reg;
    end else if (tick) begin
      cnt    <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PRE_LOG = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_out,
  output logic             armed
);

  logic             en, pulse, inv, run, tick, period_end, active;
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] per_reg, wid_reg, cnt, per_sh, wid_sh;

  pwm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pulse_done(period_end), .en(en), .pulse(pulse), .inv(inv), .sel(sel),
    .per_reg(per_reg), .wid_reg(wid_reg), .armed(armed)
  );

  assign run = en && (!pulse || armed);

  pwm_prescaler #(.PRE_LOG(PRE_LOG)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .sel(sel), .tick(tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .per_reg(per_reg),
    .wid_reg(wid_reg), .cnt(cnt), .per_sh(per_sh), .wid_sh(wid_sh),
    .period_end(period_end), .active(active)
  );

  assign pwm_out = active ^ inv;

endmodule

// File: rtl/pwm_channel_chk.sv
module pwm_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             pulse,
  input logic             inv,
  input logic             run,
  input logic             armed,
  input logic             tick,
  input logic             period_end,
  input logic [3:0]       sel,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] per_sh,
  input logic [CNT_W-1:0] wid_sh,
  input logic             pwm_out,
  input logic             wr_en,
  input logic [1:0]       wr_addr
);

  // R2
  full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && sel == 4'd0) |-> tick);

  // R2
  tick_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= per_sh);

  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> cnt == '0);

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !period_end) |=> ($stable(per_sh) && $stable(wid_sh)));

  // R7
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> pwm_out == inv);

  // R8
  pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !armed) |-> pwm_out == inv);

  // R9
  arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && period_end && !(wr_en && wr_addr == 2'd0)) |=> !armed);

endmodule

bind pwm_channel pwm_channel_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .pulse(pulse), .inv(inv), .run(run),
  .armed(armed), .tick(tick), .period_end(period_end), .sel(sel), .cnt(cnt),
  .per_sh(per_sh), .wid_sh(wid_sh), .pwm_out(pwm_out), .wr_en(wr_en),
  .wr_addr(wr_addr)
);

// File: tb/test_pwm_channel.sv
`timescale 1ns/1ps
module test_pwm_channel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  wire         pwm_out;
  wire         armed;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  pwm_channel i_pwm_channel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .armed(armed)
  );

  // {sel[4], period[16], width[16], invert, pulse}
  localparam int NV = 8;
  localparam logic [37:0] VEC [NV] = '{
    {4'd0, 16'd9, 16'd3, 1'b0, 1'b0},
    {4'd1, 16'd4, 16'd2, 1'b0, 1'b0},
    {4'd2, 16'd5, 16'd6, 1'b0, 1'b0},
    {4'd0, 16'd7, 16'd0, 1'b0, 1'b0},
    {4'd3, 16'd3, 16'd1, 1'b1, 1'b0},
    {4'd0, 16'd0, 16'd1, 1'b0, 1'b0},
    {4'd0, 16'd5, 16'd2, 1'b0, 1'b1},
    {4'd1, 16'd6, 16'd3, 1'b1, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_ctrl(input bit e, input bit p, input bit iv,
                                          input bit st, input logic [3:0] s);
    return {8'h00, s, st, iv, p, e};
  endfunction

  function automatic int divisor(input int s);
    return 1 << ((s > 12) ? 12 : s);
  endfunction

  // Expected active state i clocks after the enabling write.
  function automatic bit model_active(input int i, input int d, input int p,
                                      input int w, input bit pm);
    int k;
    k = i / d;
    if (pm && k > p) return 1'b0;
    return (k % (p + 1)) < w;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_vec(input int s, input int p, input int w, input bit iv,
                         input bit pm, input string tag);
    int d, n, bad, first;
    wr(2'd0, mk_ctrl(1'b0, 1'b0, iv, 1'b0, 4'(s)));
    chk(pwm_out === iv, "R7 idle level", pwm_out, iv);
    wr(2'd1, 16'(p));
    wr(2'd2, 16'(w));
    wr(2'd0, mk_ctrl(1'b1, pm, iv, pm, 4'(s)));
    d = divisor(s);
    n = pm ? (p + 1) * d + 4 : 2 * (p + 1) * d + 3;
    if (pm) chk(armed === 1'b1, "R9 armed after start", armed, 1);
    bad = 0; first = -1;
    for (int i = 0; i < n; i++) begin
      if (pwm_out !== (model_active(i, d, p, w, pm) ^ iv)) begin
        if (bad == 0) first = i;
        bad++;
      end
      @(negedge clk);
    end
    if (bad != 0) $display("  %s first mismatch at clock %0d", tag, first);
    chk(bad == 0, tag, bad, 0);
    if (pm) begin
      chk(armed === 1'b0, "R9 armed self-clear", armed, 0);
      chk(pwm_out === iv, "R8 inactive after pulse", pwm_out, iv);
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int hi, bad;
    repeat (3) @(negedge clk);
    chk(pwm_out === 1'b0, "R7 reset output", pwm_out, 0);
    chk(armed === 1'b0, "R9 reset armed", armed, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R1 R2 R3 R4 R5 R8
    for (int v = 0; v < NV; v++) begin
      run_vec(int'(VEC[v][37:34]), int'(VEC[v][33:18]), int'(VEC[v][17:2]),
              VEC[v][1], VEC[v][0],
              VEC[v][0] ? "R8 pulse waveform" : "R3 R4 R5 cycle waveform");
    end

    // R6: width change mid-period waits for the boundary
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'd9);
    wr(2'd2, 16'd3);
    wr(2'd0, mk_ctrl(1'b1, 1'b0, 1'b0, 1'b0, 4'd0));
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      bit e;
      e = (i < 10) ? (i < 3) : ((i - 10) < 7);
      if (pwm_out !== e) bad++;
      if (i == 4) begin wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'd7; end
      @(negedge clk);
      wr_en = 1'b0;
    end
    chk(bad == 0, "R6 shadowed width", bad, 0);

    // R7: disable mid-run with invert set, then re-enable restarts at count 0
    wr(2'd0, mk_ctrl(1'b0, 1'b0, 1'b1, 1'b0, 4'd0));
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      if (pwm_out !== 1'b1) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R7 disabled holds inactive", bad, 0);
    wr(2'd0, mk_ctrl(1'b1, 1'b0, 1'b0, 1'b0, 4'd0));
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      if (pwm_out !== model_active(i, 1, 9, 7, 1'b0)) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R7 restart from zero", bad, 0);

    // R2: select 15 clamps to divide by 4096
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'd0);
    wr(2'd2, 16'd1);
    wr(2'd0, mk_ctrl(1'b1, 1'b1, 1'b0, 1'b1, 4'd15));
    hi = 0;
    for (int i = 0; i < 4096 + 20; i++) begin
      if (pwm_out === 1'b1) hi++;
      @(negedge clk);
    end
    chk(hi == 4096, "R2 clamped divisor", hi, 4096);
    chk(armed === 1'b0, "R9 clear after long pulse", armed, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule